// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces auto-refresh for a DDR2 SDRAM controller. A down-counter runs at the controller clock and expires once per refresh interval. Each expiry adds one owed refresh. The block requests a refresh for as long as any refresh is owed, and the command arbiter answers each refresh it issues with a one-cycle acknowledge.

The interval has two values. The long interval, nominally 7.8 µs, is for case temperatures up to 85 °C. The short interval, 3.9 µs, covers the 85–95 °C band and also the optional 95–105 °C band; at the short interval the whole array is refreshed every 32 ms. Both intervals are given in nanoseconds together with the clock period, and the cycle counts are derived from them. The extended band is accepted only when a configuration input allows it. Whenever the short interval is selected, the block raises a flag. The controller uses that flag to set the high-temperature self-refresh bit (A7 of the second extended mode register) before it enters self-refresh. While self-refresh is active, pacing stops and the owed count is dropped.

Top module: `refresh_sched`

## Requirements
- R1: After reset, owed_o is 0 and ref_req_o, urgent_o and hot_sr_o are low. The long interval is selected.
- R2: With the long interval selected and no acknowledge, owed_o equals floor(k / CYC_NORM) after k clock edges following reset release or self-refresh exit, where CYC_NORM = REFI_NORM_NS*1000/CLK_PS. Whenever an expiry occurs, the counter reloads CYC_NORM-1.
- R3: Range code 1 on temp_range_i selects the short interval, CYC_HOT = REFI_HOT_NS*1000/CLK_PS cycles.
- R4: A change of range does not cut short the interval in progress. The new length applies from the reload at the next expiry.
- R5: hot_sr_o goes high one clock edge after temp_range_i shows code 1, or shows code 2 or 3 while ext_range_en_i is high. It goes low one edge after code 0.
- R6: Codes 2 and 3 presented while ext_range_en_i is low are ignored. The selected range and hot_sr_o keep their previous values.
- R7: ref_req_o is high exactly while owed_o is nonzero. Once raised, it stays high until an acknowledge arrives or self-refresh clears the count.
- R8: An acknowledge in a cycle with no expiry reduces owed_o by 1. An acknowledge while owed_o is 0 has no effect. An acknowledge in the same cycle as an expiry leaves owed_o unchanged.
- R9: owed_o saturates at OWED_MAX (8). Expiries beyond that are dropped. urgent_o is high exactly while owed_o equals OWED_MAX.
- R10: While self_ref_i is high, owed_o is 0 one edge later and the counter holds at its reload value. After self_ref_i falls, the first expiry comes a full interval later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_range_i | input | 2 | Case-temperature band: 0 up to 85 °C, 1 from 85 to 95 °C, 2 or 3 from 95 to 105 °C |
| ext_range_en_i | input | 1 | Enables the 95–105 °C band codes |
| self_ref_i | input | 1 | DRAM is in self-refresh |
| ref_ack_i | input | 1 | One refresh has been issued |
| ref_req_o | output | 1 | At least one refresh is owed |
| owed_o | output | $clog2(OWED_MAX+1) | Count of owed refreshes |
| urgent_o | output | 1 | Owed count has reached its ceiling |
| hot_sr_o | output | 1 | Short interval selected; set the high-temperature self-refresh bit |

## Verification
The bench targets the off-by-one placement of the first expiry after reset and after self-refresh exit. A counter that reloads the full count instead of count minus one would drift one cycle late on every interval. It also targets a range switch in the middle of an interval: an eager design would restart the counter at once and produce the next request too early. Saturation at eight is covered, since a wrapping counter would fall back to zero and drop the request. The two acknowledge corners are covered as well: an acknowledge with nothing owed would underflow the count, and an acknowledge that coincides with an expiry would lose or double-count a refresh. Disabled extended-band codes are checked too, because a design that honours them would flip the self-refresh flag when it should not.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [1:0] {
    TR_NORMAL  = 2'd0,
    TR_HOT     = 2'd1,
    TR_EXT     = 2'd2,
    TR_EXT_ALT = 2'd3
  } temp_range_e;
endpackage

// File: rtl/refsched_range_sel.sv
module refsched_range_sel
  import refsched_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] temp_range_i,
  input  logic       ext_en_i,
  output logic       hot_o
);
  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q <= 1'b0;
    end else begin
      case (temp_range_e'(temp_range_i))
        TR_NORMAL: hot_q <= 1'b0;
        TR_HOT:    hot_q <= 1'b1;
        default:   if (ext_en_i) hot_q <= 1'b1; // disabled band codes: hold
      endcase
    end
  end

  assign hot_o = hot_q;
endmodule

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int unsigned CYC_NORM = 1560,
  parameter int unsigned CYC_HOT  = 780,
  parameter int unsigned W        = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam logic [W-1:0] RLD_NORM = W'(CYC_NORM - 1);
  localparam logic [W-1:0] RLD_HOT  = W'(CYC_HOT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] rld;

  assign rld = hot_i ? RLD_HOT : RLD_NORM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= RLD_NORM;
    else if (hold_i)           cnt_q <= rld;
    else if (cnt_q == '0)      cnt_q <= rld;  // new range takes effect here only
    else                       cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = !hold_i && (cnt_q == '0);
endmodule

// File: rtl/refsched_owed.sv
module refsched_owed #(
  parameter int unsigned OWED_MAX = 8,
  parameter int unsigned W        = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         expire_i,
  input  logic         ack_i,
  input  logic         clear_i,
  output logic [W-1:0] owed_o
);
  localparam logic [W-1:0] MAX_V = W'(OWED_MAX);

  logic [W-1:0] owed_q;
  logic         ack_ok;

  assign ack_ok = ack_i && (owed_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q <= '0;
    end else if (clear_i) begin
      owed_q <= '0;
    end else begin
      case ({expire_i, ack_ok})
        2'b10:   if (owed_q != MAX_V) owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign owed_o = owed_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned CLK_PS       = 5000,
  parameter int unsigned REFI_NORM_NS = 7800,
  parameter int unsigned REFI_HOT_NS  = 3900,
  parameter int unsigned OWED_MAX     = 8,
  localparam int unsigned OWED_W      = $clog2(OWED_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        temp_range_i,
  input  logic              ext_range_en_i,
  input  logic              self_ref_i,
  input  logic              ref_ack_i,
  output logic              ref_req_o,
  output logic [OWED_W-1:0] owed_o,
  output logic              urgent_o,
  output logic              hot_sr_o
);
  // Round down: a shorter interval is the safe side.
  localparam int unsigned CYC_NORM = (REFI_NORM_NS * 1000) / CLK_PS;
  localparam int unsigned CYC_HOT  = (REFI_HOT_NS * 1000) / CLK_PS;
  localparam int unsigned TMR_W    = $clog2(CYC_NORM > CYC_HOT ? CYC_NORM : CYC_HOT);

  logic hot;
  logic expire;

  refsched_range_sel u_range (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .temp_range_i (temp_range_i),
    .ext_en_i     (ext_range_en_i),
    .hot_o        (hot)
  );

  refsched_timer #(
    .CYC_NORM (CYC_NORM),
    .CYC_HOT  (CYC_HOT),
    .W        (TMR_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hot_i    (hot),
    .hold_i   (self_ref_i),
    .expire_o (expire)
  );

  refsched_owed #(
    .OWED_MAX (OWED_MAX),
    .W        (OWED_W)
  ) u_owed (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .ack_i    (ref_ack_i),
    .clear_i  (self_ref_i),
    .owed_o   (owed_o)
  );

  assign ref_req_o = (owed_o != '0);
  assign urgent_o  = (owed_o == OWED_W'(OWED_MAX));
  assign hot_sr_o  = hot;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned OWED_MAX = 8,
  parameter int unsigned OWED_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        temp_range_i,
  input logic              ext_range_en_i,
  input logic              self_ref_i,
  input logic              ref_ack_i,
  input logic              ref_req_o,
  input logic [OWED_W-1:0] owed_o,
  input logic              urgent_o,
  input logic              hot_sr_o
);
  // R9
  owed_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_o <= OWED_W'(OWED_MAX));

  // R10
  sr_clears_owed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_i |=> owed_o == '0);

  // R7
  req_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && !ref_ack_i && !self_ref_i |=> ref_req_o);

  // R8
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_i && owed_o == '0 && !self_ref_i |=> owed_o <= OWED_W'(1));

  // R5
  hot_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_range_i == 2'd1 |=> hot_sr_o);

  // R5
  cool_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_range_i == 2'd0 |=> !hot_sr_o);

  // R6
  ext_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_range_i[1] && !ext_range_en_i |=> $stable(hot_sr_o));
endmodule

bind refresh_sched refresh_sched_chk #(
  .OWED_MAX (OWED_MAX),
  .OWED_W   (OWED_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .temp_range_i   (temp_range_i),
  .ext_range_en_i (ext_range_en_i),
  .self_ref_i     (self_ref_i),
  .ref_ack_i      (ref_ack_i),
  .ref_req_o      (ref_req_o),
  .owed_o         (owed_o),
  .urgent_o       (urgent_o),
  .hot_sr_o       (hot_sr_o)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
  localparam int CLK_PS = 5000;
  localparam int NORM_NS = 60;   // 12 cycles
  localparam int HOT_NS  = 30;   // 6 cycles
  localparam int NN = NORM_NS * 1000 / CLK_PS;
  localparam int NH = HOT_NS * 1000 / CLK_PS;
  localparam int MAXO = 8;
  localparam int OW = $clog2(MAXO + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] temp = 2'd0;
  logic ext_en = 1'b0;
  logic sr = 1'b0;
  logic ack = 1'b0;
  logic req, urgent, hot;
  logic [OW-1:0] owed;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  refresh_sched #(
    .CLK_PS (CLK_PS), .REFI_NORM_NS (NORM_NS), .REFI_HOT_NS (HOT_NS), .OWED_MAX (MAXO)
  ) u0 (
    .clk_i (clk), .rst_ni (rst_n), .temp_range_i (temp), .ext_range_en_i (ext_en),
    .self_ref_i (sr), .ref_ack_i (ack), .ref_req_o (req), .owed_o (owed),
    .urgent_o (urgent), .hot_sr_o (hot)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_owed(input string rq, input int exp);
    chk(rq, int'(owed), exp);
    chk({rq, " req"}, int'(req), int'(exp != 0));
    chk({rq, " urgent"}, int'(urgent), int'(exp == MAXO));
  endtask

  // Hold self-refresh a few edges with the given range, then release in phase.
  task automatic resync(input logic [1:0] t, input logic e);
    sr = 1'b1; temp = t; ext_en = e;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R10 owed in self-refresh", int'(owed), 0);
    end
    sr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_owed("R1", 0);
    chk("R1 hot flag", int'(hot), 0);
    rst_n = 1'b1;

    // R2 / R9 / R7 long-interval sweep to saturation
    for (int k = 1; k <= 110; k++) begin
      step();
      chk_owed("R2 R9 R7 normal sweep", (k / NN) > MAXO ? MAXO : (k / NN));
    end

    // R10 self-refresh clears, then R8 acknowledge corners
    resync(2'd0, 1'b0);
    for (int k = 1; k <= 36; k++) step();
    chk_owed("R10 R2 after exit", 3);
    ack = 1'b1;
    step(); chk_owed("R8 ack dec", 2);   // k=37
    step(); chk_owed("R8 ack dec", 1);   // k=38
    step(); chk_owed("R8 ack dec", 0);   // k=39
    step(); chk_owed("R8 ack at zero", 0); // k=40
    ack = 1'b0;
    for (int k = 41; k <= 48; k++) step();
    chk_owed("R8 R2 next expiry", 1);    // k=48
    for (int k = 49; k <= 59; k++) step();
    chk_owed("R7 req held", 1);
    ack = 1'b1;
    step(); chk_owed("R8 ack with expiry", 1); // k=60
    ack = 1'b0;

    // R3 / R5 short interval
    resync(2'd1, 1'b0);
    chk("R5 hot flag code1", int'(hot), 1);
    for (int k = 1; k <= 30; k++) begin
      step();
      chk_owed("R3 hot sweep", k / NH);
    end

    // R4 range change mid-interval
    resync(2'd1, 1'b0);
    for (int k = 1; k <= 3; k++) step();
    temp = 2'd0;
    step(); chk("R5 flag drops", int'(hot), 0); // k=4
    step(); chk_owed("R4 before", 0);           // k=5
    step(); chk_owed("R4 hot period kept", 1);  // k=6
    for (int k = 7; k <= 17; k++) step();
    chk_owed("R4 long reload", 1);              // k=17
    step(); chk_owed("R4 long expiry", 2);      // k=18

    // R6 / R5 extended band gating
    resync(2'd0, 1'b0);
    chk("R5 flag normal", int'(hot), 0);
    temp = 2'd2;
    step(); chk("R6 code2 disabled", int'(hot), 0);
    temp = 2'd3;
    step(); chk("R6 code3 disabled", int'(hot), 0);
    ext_en = 1'b1;
    step(); chk("R5 code3 enabled", int'(hot), 1);
    temp = 2'd1;
    step();
    ext_en = 1'b0; temp = 2'd2;
    step(); chk("R6 code2 disabled holds hot", int'(hot), 1);
    temp = 2'd0;
    step(); chk("R5 code0", int'(hot), 0);
    ext_en = 1'b1; temp = 2'd2;
    step(); chk("R5 code2 enabled", int'(hot), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule